// File: doc/BRIEF.md
# Real-Time Clock Time-of-Day Update Engine

This block keeps the calendar state of a real-time clock: seconds, minutes, hours, weekday, day of month, month and year, plus alarm values for seconds, minutes and hours. Each one-second `tick` starts an update. A busy status goes high for a fixed lead-in window. Then all time fields advance by one second in a single cycle, with carries rippling up through the calendar. The busy status then drops, and an end-of-update pulse is raised together with an alarm pulse when the new time matches the alarm.

Software reads and writes the registers by index. Three control inputs are selected at run time:
- The number format is BCD or plain binary.
- The hour format is 24-hour, or 12-hour with a PM flag in hours bit 7.
- An inhibit input holds the time still so that software can load a new value without racing the update.

Tick generation and daylight-saving adjustment happen outside this block.

Top module: `rtc_time_engine`

## Requirements
- R1: After reset, every register reads 0 except weekday, day of month and month, which read 1. `updBusy`, `updEnded` and `alarmHit` are 0.
- R2: Register indices are: 0 seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 weekday (1..7), 7 day of month, 8 month, 9 year (0..99). A write with `regWe` stores `regWdata` at `regAddr`, and `regRdata` shows the addressed register combinationally. Indices 10 to 15 read 0, and writes to them change nothing.
- R3: When `tick` is sampled high while idle and `ctlSet` is 0, `updBusy` is high from the next cycle for LEAD_CYCLES+1 cycles. In the cycle where `updBusy` falls, `updEnded` is high for exactly one cycle and the registers already hold the advanced time.
- R4: While `ctlSet` is 1, a tick starts no update: `updBusy` stays 0 and the time is unchanged. If `ctlSet` rises during the lead-in, the pending update is dropped without an `updEnded` pulse and the time is unchanged.
- R5: With `ctlBinary`=0, every field is two BCD digits (tens in bits 7:4, units in 3:0). Seconds and minutes count 0..59 and wrap to 0 with a carry into the next field.
- R6: With `ctlBinary`=1, every field holds the plain binary value, and the counting ranges and carries are the same as in BCD.
- R7: With `ctl24h`=1, hours count 0..23. A wrap from 23 to 0 advances the day of month and the weekday, and the weekday wraps from 7 to 1.
- R8: With `ctl24h`=0, hours bits 6:0 hold 1..12 and bit 7 is PM. The sequence is 12, 1, 2 ... 11, and 12 follows 11 with the PM bit toggled. Only the change from 11 PM to 12 AM advances the day.
- R9: The day of month wraps to 1 after the last day of its month, and the month advances. April, June, September and November have 30 days. February has 29 days when year mod 4 is 0 and 28 otherwise. The other months have 31 days. December wraps to January, and the year advances, wrapping from 99 to 0.
- R10: `alarmHit` pulses together with `updEnded` exactly when the updated seconds, minutes and hours registers are bit-for-bit equal to the alarm registers at indices 1, 3 and 5.
- R11: A tick that arrives while an update is in progress is ignored: the time advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update request |
| ctlSet | input | 1 | Update inhibit for time loading |
| ctlBinary | input | 1 | 1 = binary fields, 0 = BCD fields |
| ctl24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register index |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Addressed register value |
| updBusy | output | 1 | Update in progress (lead-in and step) |
| updEnded | output | 1 | One-cycle pulse when an update completes |
| alarmHit | output | 1 | One-cycle pulse when the new time equals the alarm |

## Verification
The bench loads times that sit just before a rollover, so that each carry chain is exercised. These include the full year-end wrap, February in leap and non-leap years, 30-day months, and the 11-to-12 hour change in both halves of the day. A design with a wrong month table or leap test would stop on an invalid date. A design with a misplaced PM toggle would flip AM/PM at 12 to 1 or skip a day.

The bench also aims at the control edges:
- a tick under inhibit;
- inhibit raised mid lead-in, where a faulty design would still advance or pulse end-of-update;
- a second tick during busy, which a faulty design would count twice;
- alarms that match only partly, which a faulty design would fire on.

Random times in both number formats and both hour formats are checked against a bench model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_REGS = 10;
  localparam int IDX_SEC  = 0;
  localparam int IDX_ASEC = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_AMIN = 3;
  localparam int IDX_HR   = 4;
  localparam int IDX_AHR  = 5;
  localparam int IDX_WDAY = 6;
  localparam int IDX_MDAY = 7;
  localparam int IDX_MON  = 8;
  localparam int IDX_YEAR = 9;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic doStep;
    logic doFin;
  } rtcStrobe_t;

  // stored field -> binary count
  function automatic logic [6:0] fromField(input logic [7:0] v, input logic isBin);
    logic [6:0] tens;
    tens = {3'b000, v[7:4]} * 7'd10;
    return isBin ? v[6:0] : tens + {3'b000, v[3:0]};
  endfunction

  // binary count -> stored field
  function automatic logic [7:0] toField(input logic [6:0] b, input logic isBin);
    logic [6:0] t;
    logic [6:0] u;
    t = b / 7'd10;
    u = b % 7'd10;
    return isBin ? {1'b0, b} : {t[3:0], u[3:0]};
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int LEAD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       ctlSet,
  output rtcStrobe_t strobe,
  output logic       busy
);
  localparam int CW = $clog2(LEAD_CYCLES + 1);
  localparam logic [CW-1:0] LAST_LEAD = CW'(LEAD_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_STEP, ST_FIN} seqState_t;
  seqState_t state;
  logic [CW-1:0] leadCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      leadCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (tick && !ctlSet) begin
          state   <= ST_LEAD;
          leadCnt <= '0;
        end
        ST_LEAD: begin
          if (ctlSet) state <= ST_IDLE;
          else if (leadCnt == LAST_LEAD) state <= ST_STEP;
          else leadCnt <= leadCnt + 1'b1;
        end
        ST_STEP: state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state == ST_LEAD) || (state == ST_STEP);
  assign strobe.doStep = (state == ST_STEP);
  assign strobe.doFin  = (state == ST_FIN);
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic              ctlBinary,
  input  logic              ctl24h,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              alarmHit
);
  logic [7:0] rf  [NUM_REGS];
  logic [7:0] nxt [NUM_REGS];
  logic [6:0] secB, minB, hrB, wdB, mdB, moB, yrB, hrN;
  logic [7:0] hrF;
  logic pm, pmN, minC, hrC, dayC;

  function automatic logic [6:0] daysIn(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2: return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default: return 7'd31;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) nxt[i] = rf[i];
    secB = fromField(rf[IDX_SEC], ctlBinary);
    minB = fromField(rf[IDX_MIN], ctlBinary);
    hrB  = fromField(ctl24h ? rf[IDX_HR] : {1'b0, rf[IDX_HR][6:0]}, ctlBinary);
    pm   = rf[IDX_HR][7] & ~ctl24h;
    wdB  = fromField(rf[IDX_WDAY], ctlBinary);
    mdB  = fromField(rf[IDX_MDAY], ctlBinary);
    moB  = fromField(rf[IDX_MON], ctlBinary);
    yrB  = fromField(rf[IDX_YEAR], ctlBinary);
    minC = (secB == 7'd59);
    hrC  = minC && (minB == 7'd59);
    dayC = 1'b0;
    hrN  = hrB;
    pmN  = pm;
    hrF  = rf[IDX_HR];
    nxt[IDX_SEC] = toField(minC ? 7'd0 : secB + 7'd1, ctlBinary);
    if (minC) nxt[IDX_MIN] = toField((minB == 7'd59) ? 7'd0 : minB + 7'd1, ctlBinary);
    if (hrC) begin
      if (ctl24h) begin
        if (hrB == 7'd23) begin
          hrN  = 7'd0;
          dayC = 1'b1;
        end else hrN = hrB + 7'd1;
      end else if (hrB == 7'd12) hrN = 7'd1;
      else if (hrB == 7'd11) begin
        hrN  = 7'd12;
        pmN  = ~pm;
        dayC = pm;
      end else hrN = hrB + 7'd1;
      hrF = toField(hrN, ctlBinary);
      nxt[IDX_HR] = ctl24h ? hrF : {pmN, hrF[6:0]};
    end
    if (dayC) begin
      nxt[IDX_WDAY] = toField((wdB == 7'd7) ? 7'd1 : wdB + 7'd1, ctlBinary);
      if (mdB == daysIn(moB, yrB)) begin
        nxt[IDX_MDAY] = toField(7'd1, ctlBinary);
        if (moB == 7'd12) begin
          nxt[IDX_MON]  = toField(7'd1, ctlBinary);
          nxt[IDX_YEAR] = toField((yrB == 7'd99) ? 7'd0 : yrB + 7'd1, ctlBinary);
        end else nxt[IDX_MON] = toField(moB + 7'd1, ctlBinary);
      end else nxt[IDX_MDAY] = toField(mdB + 7'd1, ctlBinary);
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL =
      (g == IDX_WDAY || g == IDX_MDAY || g == IDX_MON) ? 8'd1 : 8'd0;
    always_ff @(posedge clk) begin
      if (!rstN) rf[g] <= RST_VAL;
      else if (regWe && regAddr == ADDR_W'(g)) rf[g] <= regWdata;
      else if (strobe.doStep) rf[g] <= nxt[g];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (regAddr == ADDR_W'(i)) regRdata = rf[i];
  end

  assign alarmHit = strobe.doFin && (rf[IDX_SEC] == rf[IDX_ASEC]) &&
                    (rf[IDX_MIN] == rf[IDX_AMIN]) && (rf[IDX_HR] == rf[IDX_AHR]);
endmodule

// File: rtl/rtc_time_engine.sv
module rtc_time_engine
  import rtc_pkg::*;
#(
  parameter int LEAD_CYCLES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              ctlSet,
  input  logic              ctlBinary,
  input  logic              ctl24h,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              updBusy,
  output logic              updEnded,
  output logic              alarmHit
);
  rtcStrobe_t strobe;

  rtc_ctrl #(.LEAD_CYCLES(LEAD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .ctlSet(ctlSet),
    .strobe(strobe), .busy(updBusy)
  );

  rtc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctlBinary(ctlBinary),
    .ctl24h(ctl24h), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .alarmHit(alarmHit)
  );

  assign updEnded = strobe.doFin;
endmodule

// File: rtl/rtc_time_chk.sv
module rtc_time_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic ctlSet,
  input logic updBusy,
  input logic updEnded,
  input logic alarmHit
);
  // R3
  busy_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updBusy) |-> $past(tick));
  // R3
  ended_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEnded |-> (!updBusy && $past(updBusy)));
  // R3
  ended_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEnded |=> !updEnded);
  // R4
  set_blocks_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSet && !updBusy) |=> !updBusy);
  // R10
  alarm_with_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmHit |-> updEnded);
endmodule

bind rtc_time_engine rtc_time_chk u_chk (.*);

// File: tb/test_rtc_time_engine.sv
module test_rtc_time_engine;
  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 8;

  logic clk = 0, rstN = 0, tick = 0, ctlSet = 0, ctlBinary = 0, ctl24h = 1;
  logic regWe = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic updBusy, updEnded, alarmHit;

  int checks = 0, failures = 0, endCount = 0;
  int m [10];
  bit mBin, m24;

  rtc_time_engine #(.LEAD_CYCLES(LEAD), .ADDR_W(4)) i_rtc_time_engine (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (updEnded) endCount++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int dec(int v);
    return mBin ? v : (v >> 4) * 10 + (v & 15);
  endfunction
  function automatic int enc(int v);
    return mBin ? v : ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep();
    int s, mi, h, wd, d, mo, y;
    bit pm, day;
    s = dec(m[0]); mi = dec(m[2]); wd = dec(m[6]); d = dec(m[7]);
    mo = dec(m[8]); y = dec(m[9]);
    pm = m24 ? 1'b0 : m[4][7];
    h = m24 ? dec(m[4]) : dec(m[4] & 8'h7f);
    day = 0;
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0;
        if (m24) begin h++; if (h == 24) begin h = 0; day = 1; end end
        else if (h == 12) h = 1;
        else if (h == 11) begin h = 12; day = pm; pm = !pm; end
        else h++;
      end
    end
    if (day) begin
      wd = (wd == 7) ? 1 : wd + 1;
      if (d == mlen(mo, y)) begin
        d = 1; mo++;
        if (mo > 12) begin mo = 1; y = (y == 99) ? 0 : y + 1; end
      end else d++;
    end
    m[0] = enc(s); m[2] = enc(mi); m[6] = enc(wd); m[7] = enc(d);
    m[8] = enc(mo); m[9] = enc(y);
    m[4] = m24 ? enc(h) : ((int'(pm) << 7) | enc(h));
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    regWe = 1; regAddr = 4'(a); regWdata = 8'(d);
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic readReg(input int a, output int d);
    regAddr = 4'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic checkAll(input string tag);
    int v;
    for (int i = 0; i < 10; i++) begin
      readReg(i, v);
      check(v == m[i], $sformatf("%s reg%0d", tag, i), v, m[i]);
    end
  endtask

  // pulse tick, measure busy, check end and alarm pulses
  task automatic tickRun(input string tag, input bit expAlarm, input bit dbl);
    int busyCnt;
    bit ended, alm;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    busyCnt = 0;
    while (updBusy && busyCnt < 100) begin
      busyCnt++;
      if (dbl && busyCnt == 3) tick = 1; else tick = 0;
      @(negedge clk);
    end
    tick = 0;
    ended = updEnded; alm = alarmHit;
    check(busyCnt == LEAD + 1, {tag, " R3 busy length"}, busyCnt, LEAD + 1);
    check(ended == 1'b1, {tag, " R3 end pulse"}, int'(ended), 1);
    check(alm == expAlarm, {tag, " R10 alarm"}, int'(alm), int'(expAlarm));
    @(negedge clk);
    check(updEnded == 1'b0, {tag, " R3 end single"}, int'(updEnded), 0);
    check(updBusy == 1'b0, {tag, " R11 no second update"}, int'(updBusy), 0);
  endtask

  // alarmMode: 0 never match, 1 full match, 2 seconds-only match
  task automatic runCase(input string tag, input bit bin, input bit h24,
      input int s, input int mi, input int h, input bit pm, input int wd,
      input int d, input int mo, input int y, input int alarmMode, input bit dbl);
    int sv [10];
    bit expA;
    mBin = bin; m24 = h24;
    ctlBinary = bin; ctl24h = h24;
    m[0] = enc(s); m[2] = enc(mi); m[6] = enc(wd); m[7] = enc(d);
    m[8] = enc(mo); m[9] = enc(y);
    m[4] = h24 ? enc(h) : ((int'(pm) << 7) | enc(h));
    sv = m;
    modelStep();
    m[1] = (alarmMode != 0) ? m[0] : 8'hff;
    m[3] = (alarmMode == 1) ? m[2] : 8'hff;
    m[5] = (alarmMode == 1) ? m[4] : 8'hff;
    expA = (alarmMode == 1);
    begin
      int a1, a3, a5;
      a1 = m[1]; a3 = m[3]; a5 = m[5];
      m = sv;
      m[1] = a1; m[3] = a3; m[5] = a5;
    end
    for (int i = 0; i < 10; i++) writeReg(i, m[i]);
    modelStep();
    tickRun(tag, expA, dbl);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, e0;
    v = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      readReg(i, v);
      check(v == ((i >= 6 && i <= 8) ? 1 : 0), $sformatf("R1 reset reg%0d", i), v,
            (i >= 6 && i <= 8) ? 1 : 0);
    end
    check(updBusy == 0 && updEnded == 0 && alarmHit == 0, "R1 outputs idle",
          int'({updBusy, updEnded, alarmHit}), 0);

    // R2 index map and unused indices
    writeReg(3, 8'h42); writeReg(12, 8'ha5);
    readReg(3, v);  check(v == 8'h42, "R2 alarm minutes readback", v, 8'h42);
    readReg(12, v); check(v == 0, "R2 unused index reads 0", v, 0);
    for (int i = 0; i < 10; i++) begin
      readReg(i, v);
      check(v == ((i == 3) ? 8'h42 : ((i >= 6 && i <= 8) ? 1 : 0)),
            $sformatf("R2 index %0d unaffected", i), v, 0);
    end

    // directed rollovers
    runCase("R5 R7 R9 year end BCD", 0, 1, 59, 59, 23, 0, 7, 31, 12, 99, 1, 0);
    runCase("R9 leap feb28", 0, 1, 59, 59, 23, 0, 2, 28, 2, 24, 0, 0);
    runCase("R9 leap feb29", 0, 1, 59, 59, 23, 0, 3, 29, 2, 24, 0, 0);
    runCase("R9 plain feb28", 1, 1, 59, 59, 23, 0, 3, 28, 2, 23, 0, 0);
    runCase("R9 apr30", 0, 1, 59, 59, 23, 0, 4, 30, 4, 10, 2, 0);
    runCase("R8 11am to 12pm", 0, 0, 59, 59, 11, 0, 1, 15, 6, 5, 1, 0);
    runCase("R8 12 to 1", 0, 0, 59, 59, 12, 1, 1, 15, 6, 5, 0, 0);
    runCase("R8 11pm day carry", 1, 0, 59, 59, 11, 1, 5, 31, 1, 7, 1, 0);
    runCase("R6 binary seconds", 1, 1, 59, 12, 7, 0, 2, 3, 3, 40, 2, 0);
    runCase("R11 double tick", 0, 1, 30, 10, 5, 0, 2, 3, 3, 40, 0, 1);

    // R4 inhibit: tick ignored
    ctlSet = 1;
    e0 = endCount;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    repeat (LEAD + 4) begin
      check(updBusy == 0, "R4 no busy under inhibit", int'(updBusy), 0);
      @(negedge clk);
    end
    checkAll("R4 time held");
    ctlSet = 0;
    // R4 inhibit during lead-in
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    @(negedge clk); ctlSet = 1;
    repeat (LEAD + 4) @(negedge clk);
    check(updBusy == 0, "R4 abort drops busy", int'(updBusy), 0);
    check(endCount == e0, "R4 no end pulse", endCount - e0, 0);
    checkAll("R4 abort time held");
    ctlSet = 0;

    // random cases
    for (int k = 0; k < 60; k++) begin
      bit b, h24, pm;
      int s, mi, h, mo, y, d;
      b = 1'($urandom); h24 = 1'($urandom); pm = 1'($urandom);
      s  = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
      mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      if (h24) h = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      else h = ($urandom % 2 == 0) ? 11 : int'($urandom % 12) + 1;
      mo = int'($urandom % 12) + 1;
      y  = int'($urandom % 100);
      d  = ($urandom % 2 == 0) ? mlen(mo, y) : int'($urandom % 28) + 1;
      runCase($sformatf("RND%0d R5 R6 R7 R8 R9 R10", k), b, h24, s, mi, h, pm,
              int'($urandom % 7) + 1, d, mo, y, int'($urandom % 3), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule